// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This block gathers completion events from ten DMA channels, plus a stall event, a memory-FIFO-empty event and a bus-error event. Each event sets a sticky status bit. The block combines those status bits with enable (mask) bits and drives a single interrupt request to the processor. Software reaches everything through one 32-bit register on a simple write/read port.

A single write does two things to that register. A one written to a status bit clears that bit. A one written to a mask bit flips that mask. Zero bits leave their targets unchanged. Software can therefore acknowledge events and change the masks in one access, without a read-modify-write.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset, every status bit and mask bit is zero, the register reads 0x00000000 and `irq_o` is low.
- R2: A one-cycle pulse on `chan_done_i[n]` sets status bit n (bits 9:0). The bit reads as set from the cycle after the pulse and stays set until software clears it.
- R3: Writing a one to status bits 9:0, 13, 14 or 15 clears them. Status bits written with zero are unchanged.
- R4: Writing a one to mask bits 25:16, 29 or 30 inverts them. Mask bits written with zero are unchanged.
- R5: Pulses on `stall_i`, `fifo_empty_i` and `bus_err_i` set status bits 13, 14 and 15 respectively.
- R6: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq_o` is high exactly when one of these holds: status bit n and mask bit 16+n are both set (channel n); bits 13 and 29 are both set (stall); bits 14 and 30 are both set (FIFO-empty); or bit 15 is set (bus error, which has no mask). `irq_o` is registered, so it follows the register contents one cycle later.
- R8: Bits 10-12, 26-28 and 31 are reserved. They always read zero, and writes to them have no effect.
- R9: The read data is combinational from the register contents. A write is visible on `rd_data_o` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_done_i | input | 10 | Per-channel completion pulses |
| stall_i | input | 1 | Stall event pulse |
| fifo_empty_i | input | 1 | Memory-FIFO-empty event pulse |
| bus_err_i | input | 1 | Bus-error event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data (status: one clears; mask: one inverts) |
| rd_data_o | output | 32 | Current register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse or a write applied before clock edge k changes the register at edge k. `rd_data_o` therefore shows the new value right after edge k, and `irq_o` changes one edge later, at k+1. The bench drives its inputs on the falling edge and holds each pulse for one cycle. It samples `rd_data_o` on the next falling edge and samples `irq_o` one full cycle after that, so every check falls where its result is due. The coincident set-and-clear case and the reserved-bit writes are each checked at the register port in the cycle after the stimulus.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned NUM_CH     = 10;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CH_ST_LSB  = 0;
  localparam int unsigned CH_MSK_LSB = 16;
  localparam int unsigned STALL_ST   = 13;
  localparam int unsigned FIFO_ST    = 14;
  localparam int unsigned BERR_ST    = 15;
  localparam int unsigned STALL_MSK  = 29;
  localparam int unsigned FIFO_MSK   = 30;

  function automatic logic [REG_W-1:0] status_field();
    logic [REG_W-1:0] f;
    f = '0;
    for (int i = 0; i < int'(NUM_CH); i++) f[CH_ST_LSB+i] = 1'b1;
    f[STALL_ST] = 1'b1;
    f[FIFO_ST]  = 1'b1;
    f[BERR_ST]  = 1'b1;
    return f;
  endfunction

  function automatic logic [REG_W-1:0] mask_field();
    logic [REG_W-1:0] f;
    f = '0;
    for (int i = 0; i < int'(NUM_CH); i++) f[CH_MSK_LSB+i] = 1'b1;
    f[STALL_MSK] = 1'b1;
    f[FIFO_MSK]  = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int unsigned N = NUM_CH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] chan_ev_i,
  input  logic         stall_ev_i,
  input  logic         fifo_ev_i,
  input  logic         berr_ev_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] ch_clr_i,
  input  logic         stall_clr_i,
  input  logic         fifo_clr_i,
  input  logic         berr_clr_i,
  output logic [N-1:0] ch_st_o,
  output logic         stall_st_o,
  output logic         fifo_st_o,
  output logic         berr_st_o
);
  localparam int unsigned W = N + 3;
  logic [W-1:0] st_q, st_d, ev, clr;

  assign ev  = {berr_ev_i, fifo_ev_i, stall_ev_i, chan_ev_i};
  assign clr = {berr_clr_i, fifo_clr_i, stall_clr_i, ch_clr_i} & {W{wr_en_i}};

  genvar g;
  generate
    for (g = 0; g < int'(W); g++) begin : g_bit
      always_comb begin
        st_d[g] = st_q[g];
        if (clr[g]) st_d[g] = 1'b0;
        if (ev[g])  st_d[g] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign ch_st_o    = st_q[N-1:0];
  assign stall_st_o = st_q[N];
  assign fifo_st_o  = st_q[N+1];
  assign berr_st_o  = st_q[N+2];
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask
  import dma_irq_pkg::*;
#(
  parameter int unsigned N = NUM_CH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [N-1:0] ch_flip_i,
  input  logic         stall_flip_i,
  input  logic         fifo_flip_i,
  output logic [N-1:0] ch_msk_o,
  output logic         stall_msk_o,
  output logic         fifo_msk_o
);
  localparam int unsigned W = N + 2;
  logic [W-1:0] m_q, m_d;
  logic         m_en;

  assign m_en = wr_en_i;
  assign m_d  = m_q ^ {fifo_flip_i, stall_flip_i, ch_flip_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    m_q <= '0;
    else if (m_en) m_q <= m_d;
  end

  assign ch_msk_o    = m_q[N-1:0];
  assign stall_msk_o = m_q[N];
  assign fifo_msk_o  = m_q[N+1];
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_done_i,
  input  logic              stall_i,
  input  logic              fifo_empty_i,
  input  logic              bus_err_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ch_st, ch_msk;
  logic stall_st, fifo_st, berr_st, stall_msk, fifo_msk;
  logic irq_d, irq_q;

  dma_irq_status #(.N(NUM_CH)) u_status (
    .clk(clk), .rst_n(rst_n),
    .chan_ev_i(chan_done_i), .stall_ev_i(stall_i),
    .fifo_ev_i(fifo_empty_i), .berr_ev_i(bus_err_i),
    .wr_en_i(wr_en_i),
    .ch_clr_i(wr_data_i[CH_ST_LSB +: NUM_CH]),
    .stall_clr_i(wr_data_i[STALL_ST]),
    .fifo_clr_i(wr_data_i[FIFO_ST]),
    .berr_clr_i(wr_data_i[BERR_ST]),
    .ch_st_o(ch_st), .stall_st_o(stall_st),
    .fifo_st_o(fifo_st), .berr_st_o(berr_st)
  );

  dma_irq_mask #(.N(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
    .ch_flip_i(wr_data_i[CH_MSK_LSB +: NUM_CH]),
    .stall_flip_i(wr_data_i[STALL_MSK]),
    .fifo_flip_i(wr_data_i[FIFO_MSK]),
    .ch_msk_o(ch_msk), .stall_msk_o(stall_msk), .fifo_msk_o(fifo_msk)
  );

  always_comb begin
    rd_data_o = '0;
    rd_data_o[CH_ST_LSB +: NUM_CH]  = ch_st;
    rd_data_o[CH_MSK_LSB +: NUM_CH] = ch_msk;
    rd_data_o[STALL_ST]  = stall_st;
    rd_data_o[FIFO_ST]   = fifo_st;
    rd_data_o[BERR_ST]   = berr_st;
    rd_data_o[STALL_MSK] = stall_msk;
    rd_data_o[FIFO_MSK]  = fifo_msk;
  end

  assign irq_d = (|(ch_st & ch_msk)) | (stall_st & stall_msk) |
                 (fifo_st & fifo_msk) | berr_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_ctl_chk.sv
module dma_irq_ctl_chk
  import dma_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_done_i,
  input logic              stall_i,
  input logic              fifo_empty_i,
  input logic              bus_err_i,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              irq_o
);
  localparam logic [REG_W-1:0] LIVE = status_field() | mask_field();

  // R8
  always_comb if (rst_n) reserved_zero_chk: assert ((rd_data_o & ~LIVE) == '0);

  // R2
  chan_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done_i[0] |=> rd_data_o[0]);

  // R5
  berr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i |=> rd_data_o[BERR_ST]);

  // R3
  berr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[BERR_ST] && !(wr_en_i && wr_data_i[BERR_ST])) |=> rd_data_o[BERR_ST]);

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o & mask_field()));

  // R7
  berr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[BERR_ST] |=> irq_o);
endmodule

bind dma_irq_ctl dma_irq_ctl_chk u_chk (.*);

// File: tb/sim_dma_irq_ctl.sv
`timescale 1ns/1ps
module sim_dma_irq_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  chan_done_i;
  logic        stall_i, fifo_empty_i, bus_err_i, wr_en_i;
  logic [31:0] wr_data_i, rd_data_o;
  logic        irq_o;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_irq_ctl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    chan_done_i = '0; stall_i = 0; fifo_empty_i = 0; bus_err_i = 0;
    wr_en_i = 0; wr_data_i = '0;
  endtask

  // drive on negedge, one cycle, sample at next negedge
  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1; wr_data_i = d; step();
  endtask

  task automatic t_reset();
    chk("R1 reg", rd_data_o, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_chan();
    chan_done_i = 10'h201; step();
    chk("R2 set", rd_data_o, 32'h0000_0201);
    step();
    chk("R2 sticky", rd_data_o, 32'h0000_0201);
    chk("R7 unmasked no irq", {31'b0, irq_o}, 32'h0);
    wr(32'h0200_0000);
    chk("R4 mask flip", rd_data_o, 32'h0200_0201);
    step();
    chk("R7 ch9 irq", {31'b0, irq_o}, 32'h1);
    wr(32'h0000_0200);
    chk("R3 clear ch9", rd_data_o, 32'h0200_0001);
    step();
    chk("R7 irq drop", {31'b0, irq_o}, 32'h0);
    wr(32'h0200_0001);
    chk("R3 R4 combined", rd_data_o, 32'h0);
  endtask

  task automatic t_misc();
    stall_i = 1; fifo_empty_i = 1; step();
    chk("R5 stall fifo", rd_data_o, 32'h0000_6000);
    step();
    chk("R7 no mask", {31'b0, irq_o}, 32'h0);
    wr(32'h2000_0000);
    step();
    chk("R7 stall irq", {31'b0, irq_o}, 32'h1);
    wr(32'h2000_2000);
    wr(32'h4000_0000);
    step();
    chk("R7 fifo irq", {31'b0, irq_o}, 32'h1);
    wr(32'h4000_4000);
    chk("R3 clear fifo", rd_data_o, 32'h0);
    bus_err_i = 1; step();
    chk("R5 berr", rd_data_o, 32'h0000_8000);
    step();
    chk("R7 berr unmaskable", {31'b0, irq_o}, 32'h1);
    wr(32'h0000_8000);
    chk("R3 clear berr", rd_data_o, 32'h0);
  endtask

  task automatic t_race();
    chan_done_i = 10'h004; step();
    chan_done_i = 10'h004; wr_en_i = 1; wr_data_i = 32'h0000_0004; step();
    chk("R6 event wins", rd_data_o, 32'h0000_0004);
    wr(32'h0000_0000);
    chk("R3 zero write keeps", rd_data_o, 32'h0000_0004);
    wr(32'h0000_0004);
  endtask

  task automatic t_reserved();
    wr(32'h9C00_1C00);
    chk("R8 reserved", rd_data_o, 32'h0);
    wr(32'hFFFF_FFFF);
    chk("R9 all masks on", rd_data_o, 32'h63FF_0000);
    wr(32'h63FF_0000);
    chk("R4 invert back", rd_data_o, 32'h0);
  endtask

  initial begin
    fork
      begin
        idle(); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; step();
        t_reset(); t_chan(); t_misc(); t_race(); t_reserved();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule